// File: doc/BRIEF.md
# Snooping Four-State Cache Line Coherence Controller

This block keeps the coherence state of every line of one direct-mapped cache that shares a bus with other caches. Each line holds one data word, a tag and one of four states: Invalid, Shared, Exclusive or Modified. Local processor reads and writes are served from the line when the state allows it. Otherwise the block issues a bus transaction: a read, a read-for-ownership, an address-only invalidate or a write-back. At the same time it watches the transactions of the other caches on a snoop port and downgrades or drops its own copies to match.

A snooped read or read-for-ownership that hits a dirty line is not served cache to cache. The block raises retry in the same cycle, queues a write-back of the dirty word to memory, and then moves the line to Shared (after a read) or Invalid (after a read-for-ownership). The other cache retries later and then gets the fresh value from memory. A queued snoop write-back is serviced before any waiting local request, and a local request is held back for any cycle in which a snoop addresses the same line.

The bus side is a simple hold-until-acknowledge handshake. The bus grants one transaction per `bus_ack` pulse and never presents a snoop in the same cycle as an acknowledge to this cache. Read data and the shared indication are valid together with `bus_ack`.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snoop to any address gets no retry, and the first processor read of an address issues a bus read (command code 0) of that address.
- R2: A read miss fills the line as Exclusive when `bus_shared` is low at the acknowledge, and as Shared when it is high. The fill returns `bus_rdata` on `cpu_rdata` with the `cpu_done` pulse.
- R3: A processor write that hits an Exclusive or Modified line stores the word and makes the line Modified, with no bus transaction.
- R4: A processor write that hits a Shared line issues an invalidate (command code 2) carrying the line address, and the line then becomes Modified.
- R5: A processor write miss issues a read-for-ownership (command code 1) of the address, and the line is filled as Modified holding the written word.
- R6: A snooped invalidate (code 2) or read-for-ownership (code 1) that hits a Shared or Exclusive line makes it Invalid, with no retry.
- R7: A snooped read (code 0) that hits an Exclusive line makes it Shared, with no retry.
- R8: A snooped read or read-for-ownership that hits a Modified line raises `snp_retry` in that cycle and then issues a write-back (code 3) of the line address and word. Afterwards the line is Shared after a snooped read and Invalid after a snooped read-for-ownership. A snoop whose tag differs from the held tag never retries.
- R9: A miss on a Modified line first writes back the old address and word, then fetches the new address. A miss on a Shared or Exclusive line replaces it with no write-back.
- R10: A queued snoop write-back goes on the bus before any transaction of a waiting processor request. A processor request arriving in the same cycle as a snoop to the same line sees the state the snoop leaves behind.
- R11: When a pending invalidate for a local write finds its line invalidated by a snoop, the block issues a read-for-ownership instead, and the write still completes.
- R12: A read hit returns the stored word with no bus transaction. `cpu_done` is a one-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req_valid | output | 1 | Bus transaction request, held until `bus_ack` |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back word |
| bus_ack | input | 1 | Transaction completed this cycle |
| bus_rdata | input | DATA_W | Fill word, valid with `bus_ack` |
| bus_shared | input | 1 | Another cache holds the line, valid with `bus_ack` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_retry | output | 1 | Snooped transaction must be retried |

## Verification
The bench keeps its own memory image and a log of acknowledged bus transactions. It walks each line through every state change and checks both the order of commands and the data that reaches memory. A controller that filled a line held elsewhere as Exclusive would later upgrade it silently, so the expected invalidate would be missing from the log. A design that let a snoop dirty hit pass without retry, or that never wrote the word back, would leave the bench memory stale, and a later read would return the old value. The bench also drives a snoop and a write to the same line in one cycle, and it invalidates a line while its upgrade is held off the bus. A design that ignored snoop priority would lose the invalidate, and one that kept waiting on the upgrade would never finish the write.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_READ = 2'd0,
        BC_RFO  = 2'd1,
        BC_INV  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_EVICT = 3'd1,
        F_FILL  = 3'd2,
        F_UPGR  = 3'd3,
        F_SNPWB = 3'd4,
        F_RESP  = 3'd5
    } fsm_st_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsm_we,
    input  logic [IDX_W-1:0]  fsm_idx,
    input  line_st_e          fsm_st,
    input  logic              fsm_tag_we,
    input  logic [TAG_W-1:0]  fsm_tag,
    input  logic              fsm_data_we,
    input  logic [DATA_W-1:0] fsm_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_st,
    output line_st_e          st_o   [LINES],
    output logic [TAG_W-1:0]  tag_o  [LINES],
    output logic [DATA_W-1:0] data_o [LINES]
);

    typedef struct packed {
        line_st_e          st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        entry_t entry_d, entry_q;

        always_comb begin
            entry_d = entry_q;
            if (fsm_we && fsm_idx == IDX_W'(g)) begin
                entry_d.st = fsm_st;
                if (fsm_tag_we)  entry_d.tag  = fsm_tag;
                if (fsm_data_we) entry_d.data = fsm_data;
            end
            // snoop updates win over local ones on the same line
            if (snp_we && snp_idx == IDX_W'(g)) begin
                entry_d.st = snp_st;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '{st: LS_I, tag: '0, data: '0};
            end else begin
                entry_q <= entry_d;
            end
        end

        assign st_o[g]   = entry_q.st;
        assign tag_o[g]  = entry_q.tag;
        assign data_o[g] = entry_q.data;
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_e          st_i  [LINES],
    input  logic [TAG_W-1:0]  tag_i [LINES],
    input  logic              pend_clear,
    output logic              snp_retry,
    output logic              upd_we,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_e          upd_st,
    output logic              pend_valid,
    output logic [IDX_W-1:0]  pend_idx,
    output logic              pend_to_inv
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic             to_inv;
    } pend_t;

    pend_t pend_d, pend_q;

    logic [IDX_W-1:0] sidx;
    logic [TAG_W-1:0] stag;
    line_st_e         cur_st;
    logic             hit, is_rd, is_rfo, is_inv;

    always_comb begin
        sidx   = snp_addr[IDX_W-1:0];
        stag   = snp_addr[ADDR_W-1:IDX_W];
        cur_st = st_i[sidx];
        hit    = snp_valid && (cur_st != LS_I) && (tag_i[sidx] == stag);
        is_rd  = (snp_cmd == BC_READ);
        is_rfo = (snp_cmd == BC_RFO);
        is_inv = (snp_cmd == BC_INV);

        snp_retry = hit && (cur_st == LS_M) && (is_rd || is_rfo);

        upd_we  = 1'b0;
        upd_idx = sidx;
        upd_st  = cur_st;
        if (hit) begin
            if (is_inv) begin
                upd_we = 1'b1;
                upd_st = LS_I;
            end else if (is_rfo && cur_st != LS_M) begin
                upd_we = 1'b1;
                upd_st = LS_I;
            end else if (is_rd && cur_st == LS_E) begin
                upd_we = 1'b1;
                upd_st = LS_S;
            end
        end

        pend_d = pend_q;
        if (pend_clear) pend_d.valid = 1'b0;
        if (snp_retry) begin
            if (!pend_q.valid || pend_clear) begin
                pend_d.valid  = 1'b1;
                pend_d.idx    = sidx;
                pend_d.to_inv = is_rfo;
            end else if (pend_q.idx == sidx && is_rfo) begin
                pend_d.to_inv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_valid  = pend_q.valid;
    assign pend_idx    = pend_q.idx;
    assign pend_to_inv = pend_q.to_inv;

    // checking aid: index of the previous cycle's snoop
    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk) begin
        chk_idx_q <= sidx;
    end

    // R8
    retry_queues_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |=> pend_valid);

    // R6
    snoop_write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (is_inv || (is_rfo && cur_st != LS_M))) |=> st_i[chk_idx_q] == LS_I);

    // R7
    snoop_read_shares_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_rd && cur_st == LS_E) |=> st_i[chk_idx_q] == LS_S);

endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_st_e          st_i   [LINES],
    input  logic [TAG_W-1:0]  tag_i  [LINES],
    input  logic [DATA_W-1:0] data_i [LINES],
    input  logic              pend_valid,
    input  logic [IDX_W-1:0]  pend_idx,
    input  logic              pend_to_inv,
    output logic              pend_clear,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              bus_req_valid,
    output bus_cmd_e          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    output logic              fsm_we,
    output logic [IDX_W-1:0]  fsm_idx,
    output line_st_e          fsm_st,
    output logic              fsm_tag_we,
    output logic [TAG_W-1:0]  fsm_tag,
    output logic              fsm_data_we,
    output logic [DATA_W-1:0] fsm_data
);

    typedef struct packed {
        fsm_st_e           st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] cidx, ridx;
    logic [TAG_W-1:0] ctag, rtag;
    logic             chit, same_line_snoop;

    always_comb begin
        cidx = cpu_req_addr[IDX_W-1:0];
        ctag = cpu_req_addr[ADDR_W-1:IDX_W];
        ridx = ctl_q.addr[IDX_W-1:0];
        rtag = ctl_q.addr[ADDR_W-1:IDX_W];
        chit = (st_i[cidx] != LS_I) && (tag_i[cidx] == ctag);
        same_line_snoop = snp_valid && (snp_addr[IDX_W-1:0] == cidx);

        ctl_d       = ctl_q;
        pend_clear  = 1'b0;
        fsm_we      = 1'b0;
        fsm_idx     = ridx;
        fsm_st      = LS_I;
        fsm_tag_we  = 1'b0;
        fsm_tag     = rtag;
        fsm_data_we = 1'b0;
        fsm_data    = ctl_q.wdata;

        unique case (ctl_q.st)
            F_IDLE: begin
                if (pend_valid) begin
                    if (st_i[pend_idx] == LS_M) ctl_d.st = F_SNPWB;
                    else                        pend_clear = 1'b1;
                end else if (cpu_req_valid && !same_line_snoop) begin
                    ctl_d.wr    = cpu_req_write;
                    ctl_d.addr  = cpu_req_addr;
                    ctl_d.wdata = cpu_req_wdata;
                    fsm_idx     = cidx;
                    if (chit) begin
                        if (!cpu_req_write) begin
                            ctl_d.rdata = data_i[cidx];
                            ctl_d.st    = F_RESP;
                        end else if (st_i[cidx] == LS_S) begin
                            ctl_d.st = F_UPGR;
                        end else begin
                            fsm_we      = 1'b1;
                            fsm_st      = LS_M;
                            fsm_data_we = 1'b1;
                            fsm_data    = cpu_req_wdata;
                            ctl_d.rdata = cpu_req_wdata;
                            ctl_d.st    = F_RESP;
                        end
                    end else if (st_i[cidx] == LS_M) begin
                        ctl_d.st = F_EVICT;
                    end else begin
                        fsm_we   = 1'b1;
                        fsm_st   = LS_I;
                        ctl_d.st = F_FILL;
                    end
                end
            end
            F_EVICT: begin
                if (bus_ack) begin
                    fsm_we   = 1'b1;
                    fsm_st   = LS_I;
                    ctl_d.st = F_FILL;
                end
            end
            F_FILL: begin
                if (bus_ack) begin
                    fsm_we      = 1'b1;
                    fsm_tag_we  = 1'b1;
                    fsm_data_we = 1'b1;
                    if (ctl_q.wr) begin
                        fsm_st      = LS_M;
                        fsm_data    = ctl_q.wdata;
                        ctl_d.rdata = ctl_q.wdata;
                    end else begin
                        fsm_st      = bus_shared ? LS_S : LS_E;
                        fsm_data    = bus_rdata;
                        ctl_d.rdata = bus_rdata;
                    end
                    ctl_d.st = F_RESP;
                end
            end
            F_UPGR: begin
                if (st_i[ridx] == LS_I) begin
                    ctl_d.st = F_FILL;
                end else if (bus_ack) begin
                    fsm_we      = 1'b1;
                    fsm_st      = LS_M;
                    fsm_data_we = 1'b1;
                    ctl_d.rdata = ctl_q.wdata;
                    ctl_d.st    = F_RESP;
                end
            end
            F_SNPWB: begin
                if (bus_ack) begin
                    fsm_we     = 1'b1;
                    fsm_idx    = pend_idx;
                    fsm_st     = pend_to_inv ? LS_I : LS_S;
                    pend_clear = 1'b1;
                    ctl_d.st   = F_IDLE;
                end
            end
            F_RESP: begin
                ctl_d.st = F_IDLE;
            end
            default: ctl_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: F_IDLE, wr: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        cpu_done      = (ctl_q.st == F_RESP);
        cpu_rdata     = ctl_q.rdata;
        bus_req_valid = 1'b0;
        bus_req_cmd   = BC_READ;
        bus_req_addr  = ctl_q.addr;
        bus_req_wdata = '0;
        unique case (ctl_q.st)
            F_EVICT: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_WB;
                bus_req_addr  = {tag_i[ridx], ridx};
                bus_req_wdata = data_i[ridx];
            end
            F_FILL: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = ctl_q.wr ? BC_RFO : BC_READ;
            end
            F_UPGR: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_INV;
            end
            F_SNPWB: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_WB;
                bus_req_addr  = {tag_i[pend_idx], pend_idx};
                bus_req_wdata = data_i[pend_idx];
            end
            default: ;
        endcase
    end

    // R12
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R9
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_WB) |-> st_i[bus_req_addr[IDX_W-1:0]] == LS_M);

    // R4
    inv_only_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_INV)
            |-> (st_i[ridx] != LS_M && st_i[ridx] != LS_E));

    // R5
    write_fill_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == F_FILL && bus_ack && ctl_q.wr) |=> st_i[ridx] == LS_M);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry
);

    line_st_e          st_w   [LINES];
    logic [TAG_W-1:0]  tag_w  [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    logic              fsm_we, fsm_tag_we, fsm_data_we;
    logic [IDX_W-1:0]  fsm_idx;
    line_st_e          fsm_st;
    logic [TAG_W-1:0]  fsm_tag;
    logic [DATA_W-1:0] fsm_data;

    logic              upd_we;
    logic [IDX_W-1:0]  upd_idx;
    line_st_e          upd_st;

    logic              pend_valid, pend_to_inv, pend_clear;
    logic [IDX_W-1:0]  pend_idx;
    bus_cmd_e          bus_cmd_w;

    mesi_line_store #(
        .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .fsm_we(fsm_we), .fsm_idx(fsm_idx), .fsm_st(fsm_st),
        .fsm_tag_we(fsm_tag_we), .fsm_tag(fsm_tag),
        .fsm_data_we(fsm_data_we), .fsm_data(fsm_data),
        .snp_we(upd_we), .snp_idx(upd_idx), .snp_st(upd_st),
        .st_o(st_w), .tag_o(tag_w), .data_o(data_w)
    );

    mesi_snoop_unit #(
        .ADDR_W(ADDR_W), .LINES(LINES)
    ) snoop_i (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_addr(snp_addr),
        .st_i(st_w), .tag_i(tag_w), .pend_clear(pend_clear),
        .snp_retry(snp_retry),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_st(upd_st),
        .pend_valid(pend_valid), .pend_idx(pend_idx), .pend_to_inv(pend_to_inv)
    );

    mesi_ctrl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .st_i(st_w), .tag_i(tag_w), .data_i(data_w),
        .pend_valid(pend_valid), .pend_idx(pend_idx), .pend_to_inv(pend_to_inv),
        .pend_clear(pend_clear),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_cmd_w),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
        .fsm_we(fsm_we), .fsm_idx(fsm_idx), .fsm_st(fsm_st),
        .fsm_tag_we(fsm_tag_we), .fsm_tag(fsm_tag),
        .fsm_data_we(fsm_data_we), .fsm_data(fsm_data)
    );

    assign bus_req_cmd = bus_cmd_w;

    // R1
    no_retry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |-> snp_valid);

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [7:0] bus_req_addr, bus_req_wdata;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       bus_shared = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_retry;

    localparam logic [1:0] C_RD = 2'd0, C_RFO = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    always #4 clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(8), .DATA_W(8), .LINES(4)) dut_i (.*);

    int n_tests = 0, n_fail = 0;
    logic bus_hold = 1'b0;
    logic [7:0] mem [256];
    logic [1:0] log_cmd [64];
    logic [7:0] log_addr [64];
    logic [7:0] log_data [64];
    int log_n = 0;

    function automatic logic [7:0] init_val(input logic [7:0] a);
        return a * 8'd3 + 8'd1;
    endfunction

    // bus model: memory plus transaction log, one ack per request
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req_valid && !bus_hold && rst_n) begin
                if (log_n < 64) begin
                    log_cmd[log_n]  = bus_req_cmd;
                    log_addr[log_n] = bus_req_addr;
                    log_data[log_n] = bus_req_wdata;
                end
                log_n++;
                bus_rdata = mem[bus_req_addr];
                if (bus_req_cmd == C_WB) mem[bus_req_addr] = bus_req_wdata;
                bus_ack = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_log(input int base, input int k, input logic [1:0] cmd,
                             input logic [7:0] addr, input string tag);
        check(log_cmd[base+k] == cmd, {tag, " cmd"}, log_cmd[base+k], cmd);
        check(log_addr[base+k] == addr, {tag, " addr"}, log_addr[base+k], addr);
    endtask

    task automatic do_cpu(input bit wr, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        bit got = 0;
        rd = '0;
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cpu_done) begin
                rd = cpu_rdata;
                got = 1;
                break;
            end
        end
        cpu_req_valid = 1'b0;
        check(got, "R12 request completes", got, 1);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, output logic r);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        #1;
        r = snp_retry;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, 50000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       r;
        int         b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(cpu_done == 0, "R1 done low after reset", cpu_done, 0);
        check(bus_req_valid == 0, "R1 bus idle after reset", bus_req_valid, 0);
        for (int a = 0; a < 256; a += 17) begin
            snoop(C_RD, 8'(a), r);
            check(r == 0, "R1 no retry on empty cache", r, 0);
        end

        // R1 R2: read miss, not shared -> Exclusive
        b = log_n; bus_shared = 0;
        do_cpu(0, 8'h10, 0, rd);
        check(rd == init_val(8'h10), "R2 fill data", rd, init_val(8'h10));
        check(log_n - b == 1, "R1 one bus read", log_n - b, 1);
        check_log(b, 0, C_RD, 8'h10, "R1 read miss");

        // R3: write hit on Exclusive is silent
        b = log_n;
        do_cpu(1, 8'h10, 8'hAA, rd);
        check(log_n == b, "R3 silent E->M", log_n - b, 0);
        // R12: read hit
        do_cpu(0, 8'h10, 0, rd);
        check(rd == 8'hAA, "R12 read hit data", rd, 8'hAA);
        check(log_n == b, "R12 read hit no bus", log_n - b, 0);

        // R8: snooped read on Modified -> retry, write-back, Shared
        snoop(C_RD, 8'h10, r);
        check(r == 1, "R8 retry on dirty hit", r, 1);
        idle(8);
        check(log_n - b == 1, "R8 one write-back", log_n - b, 1);
        check_log(b, 0, C_WB, 8'h10, "R8 write-back");
        check(log_data[b] == 8'hAA, "R8 wb data", log_data[b], 8'hAA);
        check(mem[8'h10] == 8'hAA, "R8 memory updated", mem[8'h10], 8'hAA);
        snoop(C_RD, 8'h10, r);
        check(r == 0, "R8 no retry once Shared", r, 0);

        // R4: write hit on Shared -> invalidate, then Modified
        b = log_n;
        do_cpu(1, 8'h10, 8'hBB, rd);
        check(log_n - b == 1, "R4 one invalidate", log_n - b, 1);
        check_log(b, 0, C_INV, 8'h10, "R4 invalidate");
        snoop(C_RD, 8'h10, r);
        check(r == 1, "R4 line Modified after upgrade", r, 1);
        idle(8);
        check(mem[8'h10] == 8'hBB, "R4 upgraded data written back", mem[8'h10], 8'hBB);

        // R6: snooped RFO on Shared -> Invalid
        snoop(C_RFO, 8'h10, r);
        check(r == 0, "R6 no retry on clean hit", r, 0);
        b = log_n; bus_shared = 0;
        do_cpu(0, 8'h10, 0, rd);
        check(log_n - b == 1, "R6 read misses after snoop", log_n - b, 1);
        check_log(b, 0, C_RD, 8'h10, "R6 refetch");
        check(rd == 8'hBB, "R6 refetch data", rd, 8'hBB);

        // R2: shared fill -> write issues invalidate
        b = log_n; bus_shared = 1;
        do_cpu(0, 8'h21, 0, rd);
        bus_shared = 0;
        do_cpu(1, 8'h21, 8'h44, rd);
        check(log_n - b == 2, "R2 shared fill then upgrade", log_n - b, 2);
        check_log(b, 1, C_INV, 8'h21, "R2 shared fill");

        // R7: snooped read on Exclusive -> Shared
        do_cpu(0, 8'h22, 0, rd);
        snoop(C_RD, 8'h22, r);
        check(r == 0, "R7 no retry on Exclusive", r, 0);
        b = log_n;
        do_cpu(1, 8'h22, 8'h66, rd);
        check(log_n - b == 1, "R7 write after share", log_n - b, 1);
        check_log(b, 0, C_INV, 8'h22, "R7 line Shared");

        // R5: write miss -> RFO, Modified
        b = log_n;
        do_cpu(1, 8'h33, 8'h77, rd);
        check(log_n - b == 1, "R5 one RFO", log_n - b, 1);
        check_log(b, 0, C_RFO, 8'h33, "R5 write miss");
        snoop(C_RD, 8'h37, r);
        check(r == 0, "R8 tag mismatch no retry", r, 0);
        // R8: snooped RFO on Modified -> write-back then Invalid
        snoop(C_RFO, 8'h33, r);
        check(r == 1, "R5 R8 dirty after RFO fill", r, 1);
        idle(8);
        check(mem[8'h33] == 8'h77, "R8 RFO write-back", mem[8'h33], 8'h77);
        snoop(C_RD, 8'h33, r);
        check(r == 0, "R8 invalid after snooped RFO", r, 0);
        b = log_n; bus_shared = 1;
        do_cpu(0, 8'h33, 0, rd);
        bus_shared = 0;
        check(log_n - b == 1, "R8 reread misses", log_n - b, 1);
        check(rd == 8'h77, "R8 reread data", rd, 8'h77);

        // R9: silent eviction of clean, write-back of dirty
        b = log_n;
        do_cpu(0, 8'h14, 0, rd);
        check(log_n - b == 1, "R9 clean eviction silent", log_n - b, 1);
        check_log(b, 0, C_RD, 8'h14, "R9 clean eviction");
        do_cpu(1, 8'h14, 8'hC3, rd);
        b = log_n;
        do_cpu(0, 8'h18, 0, rd);
        check(log_n - b == 2, "R9 dirty eviction count", log_n - b, 2);
        check_log(b, 0, C_WB, 8'h14, "R9 write-back first");
        check_log(b, 1, C_RD, 8'h18, "R9 fetch second");
        check(mem[8'h14] == 8'hC3, "R9 evicted data", mem[8'h14], 8'hC3);
        check(rd == init_val(8'h18), "R9 new data", rd, init_val(8'h18));

        // R10: pending snoop write-back before a waiting request
        snoop(C_RD, 8'h21, r);
        check(r == 1, "R10 dirty snoop retry", r, 1);
        b = log_n;
        do_cpu(0, 8'h2A, 0, rd);
        check(log_n - b == 3, "R10 transaction count", log_n - b, 3);
        check_log(b, 0, C_WB, 8'h21, "R10 snoop wb first");
        check_log(b, 1, C_WB, 8'h22, "R10 eviction wb");
        check_log(b, 2, C_RD, 8'h2A, "R10 fetch last");
        check(mem[8'h21] == 8'h44 && mem[8'h22] == 8'h66, "R10 memory", mem[8'h21], 8'h44);

        // R10: same-cycle snoop read and write to the same Exclusive line
        b = log_n;
        fork
            do_cpu(1, 8'h2A, 8'h55, rd);
            snoop(C_RD, 8'h2A, r);
        join
        check(r == 0, "R10 snoop on Exclusive no retry", r, 0);
        check(log_n - b == 1, "R10 write sees Shared", log_n - b, 1);
        check_log(b, 0, C_INV, 8'h2A, "R10 snoop priority");

        // R11: upgrade overtaken by a snooped invalidate becomes RFO
        b = log_n;
        bus_hold = 1'b1;
        fork
            do_cpu(1, 8'h33, 8'h99, rd);
            begin
                idle(3);
                snoop(C_INV, 8'h33, r);
                idle(2);
                bus_hold = 1'b0;
            end
        join
        check(log_n - b == 1, "R11 single transaction", log_n - b, 1);
        check_log(b, 0, C_RFO, 8'h33, "R11 RFO after lost line");
        snoop(C_RD, 8'h33, r);
        check(r == 1, "R11 line Modified", r, 1);
        idle(8);
        check(mem[8'h33] == 8'h99, "R11 written data", mem[8'h33], 8'h99);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule